// File: doc/BRIEF.md
# Split Carry-Select Next-PC Unit

This block produces the address of the next sequential instruction during the fetch stage. An instruction can be one, two, five or six bytes long, depending on whether it carries a register-specifier byte and a four-byte constant. The usual adder waits for the instruction bytes to be decoded and then adds across the whole 32-bit width. This unit does not.

The program counter is split into a wide upper field and a narrow lower field. An incrementer adds one to the upper field as soon as the selected PC is stable, so that work runs alongside the instruction memory read. When the two length flags arrive from decode, only a small lower-field adder and a two-way select remain on the path. The carry out of the lower adder picks either the incremented or the unchanged upper field.

A parameter places a register on the output to isolate timing. In that variant, a synchronous active-low reset clears the register.

Top module: `pc_step_unit`

## Requirements
- R1: The step length is 1, plus 1 when `hasRegByte` is high, plus 4 when `hasConstWord` is high. The four flag combinations (reg, const) = 00, 10, 01, 11 give lengths 1, 2, 5 and 6.
- R2: `nextPc` equals `pcSel` plus the step length, modulo 2^32, for every input value.
- R3: When the low 3 bits of `pcSel` plus the step length stay below 8, bits [31:3] of `nextPc` equal bits [31:3] of `pcSel`.
- R4: When the low 3 bits of `pcSel` plus the step length reach 8 or more, bits [31:3] of `nextPc` equal bits [31:3] of `pcSel` plus one, modulo 2^29.
- R5: A PC near 0xFFFFFFFF whose step passes the top of the address space wraps to a small address, and no carry is kept.
- R6: With the output register enabled (the default), `nextPc` reflects the inputs present at the previous rising clock edge. The output holds that value until the next edge, even if the inputs change in between.
- R7: When `rstN` is low at a rising edge, `nextPc` becomes 0 after that edge, whatever the other inputs are.
- R8: Bits [2:0] of `nextPc` equal the low 3 bits of `pcSel` plus the step length, modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Synchronous active-low clear of the output register |
| pcSel | input | 32 | Selected program counter of the instruction being fetched |
| hasRegByte | input | 1 | Instruction carries a register-specifier byte |
| hasConstWord | input | 1 | Instruction carries a four-byte constant |
| nextPc | output | 32 | Address of the following instruction |

## Verification
Two pieces of logic can act in the same cycle: the lower-field carry that selects the incremented upper field, and the upper incrementer wrapping from all-ones to zero. Both happen when the PC lies in the last few bytes of the address space and the step crosses an 8-byte boundary. The bench drives every PC from 0xFFFFFFF8 to 0xFFFFFFFF with all four flag combinations. It judges each result against a plain 64-bit sum truncated to 32 bits, and it checks the upper and lower fields separately so that an error in either one is reported on its own.

// File: rtl/pc_step_pkg.sv
package pc_step_pkg;
  // width of the step-length code; the largest step is 6
  localparam int LEN_W = 3;
  localparam int REG_BYTES = 1;
  localparam int CONST_BYTES = 4;

  typedef struct packed {
    logic [LEN_W-1:0] stepLen;   // bytes to advance
    logic             clearOut;  // synchronous clear of the output register
  } stepCtrl_t;
endpackage

// File: rtl/pc_step_ctrl.sv
module pc_step_ctrl
  import pc_step_pkg::*;
(
  input  logic      rstN,
  input  logic      hasRegByte,
  input  logic      hasConstWord,
  output stepCtrl_t ctrl
);
  always_comb begin
    ctrl.stepLen = LEN_W'(1);
    if (hasRegByte)   ctrl.stepLen = ctrl.stepLen + LEN_W'(REG_BYTES);
    if (hasConstWord) ctrl.stepLen = ctrl.stepLen + LEN_W'(CONST_BYTES);
    ctrl.clearOut = !rstN;
  end
endmodule

// File: rtl/pc_step_hi_inc.sv
module pc_step_hi_inc #(
  parameter int W = 29
) (
  input  logic [W-1:0] hiIn,
  output logic [W-1:0] hiPlus
);
  // starts as soon as the PC is stable; does not depend on decode
  assign hiPlus = hiIn + {{(W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/pc_step_datapath.sv
module pc_step_datapath
  import pc_step_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int LOW_W   = 3,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic [PC_W-1:0] pcSel,
  input  stepCtrl_t       ctrl,
  output logic [PC_W-1:0] nextPc
);
  localparam int HI_W = PC_W - LOW_W;

  logic [HI_W-1:0]  hiPlus;
  logic [LOW_W:0]   lowSum;
  logic [PC_W-1:0]  sumComb;

  pc_step_hi_inc #(.W(HI_W)) hiInc (
    .hiIn  (pcSel[PC_W-1:LOW_W]),
    .hiPlus(hiPlus)
  );

  // narrow add on the late path: low PC bits plus decoded length
  assign lowSum = {1'b0, pcSel[LOW_W-1:0]}
                + {{(LOW_W+1-LEN_W){1'b0}}, ctrl.stepLen};

  // carry picks the pre-incremented or the unchanged upper field
  assign sumComb = {lowSum[LOW_W] ? hiPlus : pcSel[PC_W-1:LOW_W],
                    lowSum[LOW_W-1:0]};

  generate
    if (OUT_REG) begin : gReg
      logic [PC_W-1:0] outQ;
      always_ff @(posedge clk) begin
        if (ctrl.clearOut) outQ <= '0;
        else               outQ <= sumComb;
      end
      assign nextPc = outQ;
    end else begin : gComb
      assign nextPc = sumComb;
    end
  endgenerate
endmodule

// File: rtl/pc_step_unit.sv
module pc_step_unit
  import pc_step_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int LOW_W   = 3,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] pcSel,
  input  logic            hasRegByte,
  input  logic            hasConstWord,
  output logic [PC_W-1:0] nextPc
);
  stepCtrl_t ctrl;

  pc_step_ctrl ctrlU (
    .rstN        (rstN),
    .hasRegByte  (hasRegByte),
    .hasConstWord(hasConstWord),
    .ctrl        (ctrl)
  );

  pc_step_datapath #(.PC_W(PC_W), .LOW_W(LOW_W), .OUT_REG(OUT_REG)) dpU (
    .clk   (clk),
    .pcSel (pcSel),
    .ctrl  (ctrl),
    .nextPc(nextPc)
  );
endmodule

// File: rtl/pc_step_checker.sv
module pc_step_checker #(
  parameter int PC_W    = 32,
  parameter int LOW_W   = 3,
  parameter bit OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] pcSel,
  input logic            hasRegByte,
  input logic            hasConstWord,
  input logic [PC_W-1:0] nextPc
);
  logic [PC_W-1:0] stepC;
  logic [PC_W-1:0] lowExt;
  logic            lowCarry;

  assign stepC = (hasConstWord ? PC_W'(5) : PC_W'(1)) + PC_W'(hasRegByte);
  assign lowExt = {{(PC_W-LOW_W){1'b0}}, pcSel[LOW_W-1:0]};
  assign lowCarry = (lowExt + stepC) >= PC_W'(1 << LOW_W);

  generate
    if (OUT_REG) begin : gSeq
      assert_sum_R2: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> nextPc == $past(pcSel) + $past(stepC));
      assert_hi_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && !$past(lowCarry)) |->
          nextPc[PC_W-1:LOW_W] == $past(pcSel[PC_W-1:LOW_W]));
      assert_hi_inc_R4: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(lowCarry)) |->
          nextPc[PC_W-1:LOW_W] == $past(pcSel[PC_W-1:LOW_W]) + 1'b1);
      assert_clear_R7: assert property (@(posedge clk)
        !rstN |=> nextPc == '0);
    end else begin : gComb
      assert_sum_comb_R2: assert property (@(posedge clk)
        nextPc == pcSel + stepC);
      assert_hi_comb_R4: assert property (@(posedge clk)
        lowCarry |-> nextPc[PC_W-1:LOW_W] == pcSel[PC_W-1:LOW_W] + 1'b1);
      assert_hi_comb_R3: assert property (@(posedge clk)
        !lowCarry |-> nextPc[PC_W-1:LOW_W] == pcSel[PC_W-1:LOW_W]);
      assert_len_comb_R1: assert property (@(posedge clk)
        (pcSel == '0) |-> nextPc == stepC);
    end
  endgenerate
endmodule

bind pc_step_unit pc_step_checker #(.PC_W(PC_W), .LOW_W(LOW_W), .OUT_REG(OUT_REG)) chk (
  .clk(clk), .rstN(rstN), .pcSel(pcSel), .hasRegByte(hasRegByte),
  .hasConstWord(hasConstWord), .nextPc(nextPc));

// File: tb/pc_step_unit_test.sv
`timescale 1ns/1ps
module pc_step_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pcSel = '0;
  logic        hasRegByte = 1'b0;
  logic        hasConstWord = 1'b0;
  logic [31:0] nextPc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] prevExp = '0;
  logic [31:0] expQ[$];

  always #2.5 clk = ~clk;

  pc_step_unit uut (
    .clk(clk), .rstN(rstN), .pcSel(pcSel), .hasRegByte(hasRegByte),
    .hasConstWord(hasConstWord), .nextPc(nextPc));

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int stepOf(bit r, bit c);
    return 1 + (r ? 1 : 0) + (c ? 4 : 0);
  endfunction

  // drive at a falling edge, verify hold, then verify the new result
  task automatic applyVec(logic [31:0] pc, bit r, bit c, string tag);
    longint sum;
    logic [31:0] exp;
    pcSel = pc; hasRegByte = r; hasConstWord = c;
    sum = longint'(pc) + longint'(stepOf(r, c));
    exp = sum[31:0];
    expQ.push_back(exp);
    #1 checkEq("R6 output held until edge", nextPc, prevExp);
    @(negedge clk);
    exp = expQ.pop_front();
    checkEq({tag, " R2 full sum"}, nextPc, exp);
    checkEq("R8 low bits", {29'd0, nextPc[2:0]}, {29'd0, exp[2:0]});
    if ({1'b0, pc[2:0]} + 4'(stepOf(r, c)) >= 4'd8)
      checkEq("R4 upper incremented", {3'd0, nextPc[31:3]}, {3'd0, pc[31:3] + 29'd1});
    else
      checkEq("R3 upper unchanged", {3'd0, nextPc[31:3]}, {3'd0, pc[31:3]});
    if (sum >= 64'h1_0000_0000)
      checkEq("R5 wrap", nextPc, exp);
    prevExp = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    pcSel = 32'h1234_5677; hasRegByte = 1'b1; hasConstWord = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R7 reset state", nextPc, 32'h0);
    rstN = 1'b1;
    prevExp = '0;

    // R1: step length seen at the port with PC zero
    for (int k = 0; k < 4; k++)
      applyVec(32'h0, k[0], k[1], "R1 length");

    // low-field corners
    for (int lo = 0; lo < 8; lo++)
      for (int k = 0; k < 4; k++)
        applyVec(32'h0000_1000 | 32'(lo), k[0], k[1], "low corner");

    // top of the address space: carry and wrap in the same cycle
    for (int lo = 0; lo < 8; lo++)
      for (int k = 0; k < 4; k++)
        applyVec(32'hFFFF_FFF8 | 32'(lo), k[0], k[1], "R5 top");

    applyVec(32'h7FFF_FFFF, 1'b1, 1'b1, "sign boundary");
    applyVec(32'h0FFF_FFFE, 1'b0, 1'b1, "carry chain");

    // R7: clear in the middle of traffic
    @(negedge clk);
    pcSel = 32'hABCD_EF07; hasRegByte = 1'b1; hasConstWord = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    checkEq("R7 mid-run clear", nextPc, 32'h0);
    rstN = 1'b1;
    prevExp = '0;

    for (int n = 0; n < 2000; n++) begin
      logic [31:0] rp;
      logic [1:0] rf;
      rp = $urandom;
      rf = 2'($urandom);
      applyVec(rp, rf[0], rf[1], "random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule